// File: doc/BRIEF.md
# ARINC 429 Receive Bit Qualifier

This block turns a decoded ARINC 429 line into 32-bit words. The line arrives as two wires: `line_hi` marks a One level and `line_lo` marks a Zero level. Either wire alone carries a data level. Both wires low, or both wires high, is read as Null. The timing reference is a 1 MHz clock. Every accepted bit must pass two tests: its pulse shape is checked in a sliding window of samples, and its distance from the previous bit is checked in samples. Bits that pass are shifted into a word, and a one-cycle pulse announces each finished word.

After a finished word, and after any rejected reception, the block stops accepting bits. It waits until a gap timer has seen the line idle on several checks in a row, and only then arms again. This timer keeps a receiver that started in the middle of a word from emitting a misaligned word. A speed select stretches the sample interval by eight. The same sample-count rules then cover the low bit-rate range.

Top module: `arx_bit_qualifier`

## Requirements
- R1: A sample reads One when only `line_hi` is high, Zero when only `line_lo` is high, and Null in every other case, including both wires high.
- R2: A bit is recognised on the sample where a Null run reaches three samples, provided the three samples just before that run all hold the same data level. The bit value is 1 for One and 0 for Zero. Any other pulse shape, such as a data run of only two samples, discards the word being received.
- R3: Spacing is the number of samples from one recognised bit to the next. For every bit after the first in a word, a spacing of 8 to 12 samples inclusive is accepted. Any other spacing discards the word.
- R4: If a partially received word gets no further bit within 12 samples, it is discarded.
- R5: The first accepted bit of a word lands in `rx_word[0]`, and the 32nd lands in `rx_word[31]`. A One bit gives 1.
- R6: `eos` is high for exactly one clock when the 32nd bit is accepted, and `rx_word` takes the new word in that same clock. At all other times `rx_word` keeps its value.
- R7: After a word completes or is discarded, no bit is accepted until the line has been checked idle on three checks in a row. A check comes every 10 samples. A check passes when the three newest samples and the three oldest samples of the 10-sample window are all Null.
- R8: After reset, `eos` is 0 and `rx_word` is 0. The block arms once the idle line has passed the gap checks of R7.
- R9: With `speed_low` = 1, the line is sampled once every 8 clocks. All sample-count rules (R2, R3, R4, R7) then apply unchanged, so a gap check comes every 80 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz timing reference |
| rst | input | 1 | Synchronous active-high reset |
| speed_low | input | 1 | 1 selects low bit rate (sample every 8 clocks), 0 selects high rate |
| line_hi | input | 1 | Decoded One level of the line |
| line_lo | input | 1 | Decoded Zero level of the line |
| eos | output | 1 | One-clock pulse when a full 32-bit word has been collected |
| rx_word | output | 32 | Last completed word, first received bit in bit 0 |

## Verification
The checker watches several properties on every clock:
- `eos` lasts a single clock, and only when the bit counter was at its last position.
- `rx_word` never moves without `eos`.
- The bit counter is zero whenever reception is not armed.
- An arm from the gap timer always enters reception.
- At low speed, sample enables never fall on adjacent clocks.

Some behaviour only the bench scenarios can show. Each of these needs a sequence of many bits and a known data value:
- which pulse shapes and spacings are accepted or rejected, including the 7, 8, 12 and 13 sample edges
- discarding a stalled word
- refusing a word that follows too short a gap
- the bit order inside `rx_word`

// File: rtl/arx_pkg.sv
package arx_pkg;

    // Level indices of the sampling registers
    localparam int NUM_LEVELS = 3;
    localparam int LVL_NULL   = 0;
    localparam int LVL_ZERO   = 1;
    localparam int LVL_ONE    = 2;

    typedef enum logic {
        ST_WAIT_GAP = 1'b0,
        ST_RECV     = 1'b1
    } rx_state_e;

    // Outcome of the pulse classifier on one sample step
    typedef struct packed {
        logic fire;   // a Null run just reached its qualifying length
        logic bad;    // preceding data run was malformed
        logic value;  // bit value when not bad
    } bit_event_t;

    // One-hot level vector indexed by LVL_*; both wires high reads as Null
    function automatic logic [NUM_LEVELS-1:0] decode_line(input logic hi, input logic lo);
        logic [NUM_LEVELS-1:0] v;
        v           = '0;
        v[LVL_ONE]  = hi & ~lo;
        v[LVL_ZERO] = lo & ~hi;
        v[LVL_NULL] = ~(hi ^ lo);
        return v;
    endfunction

endpackage

// File: rtl/arx_tick_gen.sv
module arx_tick_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic speed_low,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt == W'(DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = speed_low ? (cnt == W'(DIV - 1)) : 1'b1;

endmodule

// File: rtl/arx_level_sampler.sv
module arx_level_sampler
    import arx_pkg::*;
#(
    parameter int SR_LEN = 10,
    parameter int RUN    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       line_hi,
    input  logic       line_lo,
    output logic       step,
    output bit_event_t ev,
    output logic       idle_ok
);
    localparam logic [SR_LEN-1:0] LOW_MASK   = SR_LEN'((1 << RUN) - 1);
    localparam logic [SR_LEN-1:0] HIGH_MASK  = LOW_MASK << (SR_LEN - RUN);
    localparam logic [SR_LEN-1:0] MID_MASK   = ~(LOW_MASK | HIGH_MASK);
    localparam logic [SR_LEN-1:0] FRESH_MASK = SR_LEN'((1 << (RUN + 1)) - 1);
    localparam logic [SR_LEN-1:0] DATA_MASK  = SR_LEN'((1 << (2 * RUN)) - 1);
    localparam logic [SR_LEN-1:0] DATA_VAL   = LOW_MASK << RUN;

    logic [NUM_LEVELS-1:0] lvl_now;
    logic [SR_LEN-1:0]     sr [NUM_LEVELS];
    logic                  upd;

    assign lvl_now = decode_line(line_hi, line_lo);

    // One sampling register per level, newest sample in stage 0
    for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
        localparam logic [SR_LEN-1:0] RST_VAL = (g == LVL_NULL) ? '1 : '0;
        always_ff @(posedge clk) begin
            if (rst) begin
                sr[g] <= RST_VAL;
            end else if (tick) begin
                sr[g] <= {sr[g][SR_LEN-2:0], lvl_now[g]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            upd <= 1'b0;
        end else begin
            upd <= tick;
        end
    end

    logic null_fresh, one_run, zero_run;

    always_comb begin
        null_fresh = ((sr[LVL_NULL] & FRESH_MASK) == LOW_MASK);
        one_run    = ((sr[LVL_ONE]  & DATA_MASK) == DATA_VAL);
        zero_run   = ((sr[LVL_ZERO] & DATA_MASK) == DATA_VAL);
        ev.fire    = upd && null_fresh;
        ev.bad     = !(one_run ^ zero_run);
        ev.value   = one_run;
        idle_ok    = &(sr[LVL_NULL] | MID_MASK);
    end

    assign step = upd;

endmodule

// File: rtl/arx_spacing_check.sv
module arx_spacing_check #(
    parameter int SPACE_MIN = 8,
    parameter int SPACE_MAX = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic restart,
    output logic in_window,
    output logic too_late
);
    localparam int SP_W = $clog2(SPACE_MAX + 2);

    logic [SP_W-1:0] sp;
    logic [SP_W-1:0] since;

    // Samples elapsed since the last accepted bit, counting the current one
    assign since     = (sp == '1) ? sp : sp + 1'b1;
    assign in_window = (since >= SP_W'(SPACE_MIN)) && (since <= SP_W'(SPACE_MAX));
    assign too_late  = (since > SP_W'(SPACE_MAX));

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (restart) begin
            sp <= '0;
        end else if (step) begin
            sp <= since;
        end
    end

endmodule

// File: rtl/arx_gap_timer.sv
module arx_gap_timer #(
    parameter int GAP_TICKS  = 10,
    parameter int GAP_NEEDED = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic start,
    input  logic idle_ok,
    output logic arm
);
    localparam int TMR_W = $clog2(GAP_TICKS);
    localparam int CNT_W = $clog2(GAP_NEEDED + 1);

    logic             active;
    logic [TMR_W-1:0] tmr;
    logic [CNT_W-1:0] hits;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            tmr    <= '0;
            hits   <= '0;
            arm    <= 1'b0;
        end else begin
            arm <= 1'b0;
            if (start) begin
                active <= 1'b1;
                tmr    <= '0;
                hits   <= '0;
            end else if (active && step) begin
                if (tmr == TMR_W'(GAP_TICKS - 1)) begin
                    tmr <= '0;
                    if (!idle_ok) begin
                        hits <= '0;
                    end else if (hits == CNT_W'(GAP_NEEDED - 1)) begin
                        hits   <= '0;
                        active <= 1'b0;
                        arm    <= 1'b1;
                    end else begin
                        hits <= hits + 1'b1;
                    end
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/arx_bit_qualifier.sv
module arx_bit_qualifier
    import arx_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int SR_LEN     = 10,
    parameter int RUN        = 3,
    parameter int SPACE_MIN  = 8,
    parameter int SPACE_MAX  = 12,
    parameter int GAP_TICKS  = 10,
    parameter int GAP_NEEDED = 3,
    parameter int LOW_DIV    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              speed_low,
    input  logic              line_hi,
    input  logic              line_lo,
    output logic              eos,
    output logic [WORD_W-1:0] rx_word
);
    localparam int BC_W = $clog2(WORD_W);

    logic       tick, step, idle_ok, in_window, too_late, gap_arm;
    bit_event_t ev;
    rx_state_e  state;
    logic       in_rx;
    logic [BC_W-1:0]   bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic accept, violation, last_bit, gap_start;

    arx_tick_gen #(.DIV(LOW_DIV)) u_tick (
        .clk(clk), .rst(rst), .speed_low(speed_low), .tick(tick)
    );

    arx_level_sampler #(.SR_LEN(SR_LEN), .RUN(RUN)) u_samp (
        .clk(clk), .rst(rst), .tick(tick), .line_hi(line_hi), .line_lo(line_lo),
        .step(step), .ev(ev), .idle_ok(idle_ok)
    );

    arx_spacing_check #(.SPACE_MIN(SPACE_MIN), .SPACE_MAX(SPACE_MAX)) u_space (
        .clk(clk), .rst(rst), .step(step), .restart(accept),
        .in_window(in_window), .too_late(too_late)
    );

    arx_gap_timer #(.GAP_TICKS(GAP_TICKS), .GAP_NEEDED(GAP_NEEDED)) u_gap (
        .clk(clk), .rst(rst), .step(step), .start(gap_start),
        .idle_ok(idle_ok), .arm(gap_arm)
    );

    assign in_rx = (state == ST_RECV);

    always_comb begin
        accept    = in_rx && ev.fire && !ev.bad && ((bit_cnt == '0) || in_window);
        violation = in_rx && !accept &&
                    (ev.fire || (step && (bit_cnt != '0) && too_late));
        last_bit  = accept && (bit_cnt == BC_W'(WORD_W - 1));
        gap_start = violation || last_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_WAIT_GAP;
            bit_cnt <= '0;
            shreg   <= '0;
            eos     <= 1'b0;
            rx_word <= '0;
        end else begin
            eos <= last_bit;
            if (last_bit) begin
                rx_word <= {ev.value, shreg[WORD_W-1:1]};
            end
            if (gap_start) begin
                state   <= ST_WAIT_GAP;
                bit_cnt <= '0;
                shreg   <= '0;
            end else if (accept) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {ev.value, shreg[WORD_W-1:1]};
            end else if (!in_rx && gap_arm) begin
                state   <= ST_RECV;
                bit_cnt <= '0;
                shreg   <= '0;
            end
        end
    end

endmodule

// File: rtl/arx_bit_qualifier_chk.sv
module arx_bit_qualifier_chk #(
    parameter int WORD_W = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      speed_low,
    input logic                      tick,
    input logic                      eos,
    input logic [WORD_W-1:0]         rx_word,
    input logic                      in_rx,
    input logic [$clog2(WORD_W)-1:0] bit_cnt,
    input logic                      gap_arm
);
    localparam int BC_W = $clog2(WORD_W);

    assert_eos_single_R6: assert property (@(posedge clk) disable iff (rst)
        eos |=> !eos);

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !eos |-> $stable(rx_word));

    assert_eos_after_last_R5: assert property (@(posedge clk) disable iff (rst)
        eos |-> ($past(in_rx) && ($past(bit_cnt) == BC_W'(WORD_W - 1))));

    assert_eos_leaves_rx_R7: assert property (@(posedge clk) disable iff (rst)
        eos |-> !in_rx);

    assert_idle_no_bits_R7: assert property (@(posedge clk) disable iff (rst)
        !in_rx |-> (bit_cnt == '0));

    assert_arm_enters_rx_R7: assert property (@(posedge clk) disable iff (rst)
        gap_arm |=> in_rx);

    assert_slow_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (speed_low && tick) |=> (!tick || !speed_low));

endmodule

bind arx_bit_qualifier arx_bit_qualifier_chk u_chk (
    .clk(clk), .rst(rst), .speed_low(speed_low), .tick(tick), .eos(eos),
    .rx_word(rx_word), .in_rx(in_rx), .bit_cnt(bit_cnt), .gap_arm(gap_arm)
);

// File: tb/arx_bit_qualifier_tb.sv
module arx_bit_qualifier_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        speed_low = 1'b0;
    logic        line_hi = 1'b0;
    logic        line_lo = 1'b0;
    logic        eos;
    logic [31:0] rx_word;

    int          n_checks = 0;
    int          n_fail   = 0;
    int          eos_seen = 0;
    int          exp_total = 0;
    logic [31:0] last_word = '0;
    logic [31:0] exp_word  = '0;
    int          div = 1;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    arx_bit_qualifier u_dut (
        .clk(clk), .rst(rst), .speed_low(speed_low),
        .line_hi(line_hi), .line_lo(line_lo),
        .eos(eos), .rx_word(rx_word)
    );

    always @(negedge clk) begin
        if (!rst && eos) begin
            eos_seen  += 1;
            last_word = rx_word;
        end
    end

    task automatic drive(input logic hi, input logic lo, input int samples);
        line_hi = hi;
        line_lo = lo;
        repeat (samples * div) @(negedge clk);
    endtask

    task automatic send_bit(input logic v, input int h, input int l, input bit both_null);
        drive(v, ~v, h);
        drive(both_null, both_null, l);
    endtask

    // Fixed-shape word; bit odd_idx uses odd_h/odd_l; only nbits bits sent
    task automatic send_word(input logic [31:0] data, input int nbits, input int h, input int l,
                             input int odd_idx, input int odd_h, input int odd_l, input bit both_null);
        for (int i = 0; i < nbits; i++) begin
            if (i == odd_idx) send_bit(data[i], odd_h, odd_l, both_null);
            else              send_bit(data[i], h, l, both_null);
        end
    endtask

    // Random shapes; spacing into bit n is l(n-1) + h(n), kept within 8..12
    task automatic send_word_rand(input logic [31:0] data);
        int lprev = 5;
        for (int i = 0; i < 32; i++) begin
            int lo_h = (8 - lprev > 3) ? 8 - lprev : 3;
            int h = (i == 0) ? 3 + int'($urandom % 4) : lo_h + int'($urandom % (7 - lo_h));
            int l = 3 + int'($urandom % 4);
            send_bit(data[i], h, l, 1'b0);
            lprev = l;
        end
    endtask

    task automatic expect_words(input int n_new, input logic [31:0] w, input string tag);
        exp_total += n_new;
        if (n_new > 0) exp_word = w;
        n_checks += 1;
        if (eos_seen != exp_total || last_word != exp_word) begin
            n_fail += 1;
            $display("FAIL %s: eos count %0d word %h, expected count %0d word %h",
                     tag, eos_seen, last_word, exp_total, exp_word);
        end
    endtask

    task automatic settle();
        drive(1'b0, 1'b0, 60);
    endtask

    initial begin
        void'($urandom(32'h5eed_0429));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        n_checks += 1;
        if (eos !== 1'b0 || rx_word !== 32'h0) begin
            n_fail += 1;
            $display("FAIL R8: eos %b word %h, expected 0 and 00000000", eos, rx_word);
        end
        drive(1'b0, 1'b0, 40);

        // R8/R2: first word after reset is accepted; random words and shapes
        for (int k = 0; k < 6; k++) begin
            logic [31:0] d = $urandom;
            send_word_rand(d);
            settle();
            expect_words(1, d, "R2 random word");
        end

        // R5: bit order
        send_word(32'h0000_0001, 32, 5, 5, -1, 0, 0, 1'b0); settle();
        expect_words(1, 32'h0000_0001, "R5 first bit at 0");
        send_word(32'h8000_0000, 32, 5, 5, -1, 0, 0, 1'b0); settle();
        expect_words(1, 32'h8000_0000, "R5 last bit at 31");

        // R1: both wires high read as Null
        send_word(32'hA5C3_0F96, 32, 5, 5, -1, 0, 0, 1'b1); settle();
        expect_words(1, 32'hA5C3_0F96, "R1 both-high null");

        // R3: spacing edges
        send_word(32'h1357_9BDF, 32, 3, 5, -1, 0, 0, 1'b0); settle();
        expect_words(1, 32'h1357_9BDF, "R3 spacing 8");
        send_word(32'hFEDC_BA98, 32, 6, 6, -1, 0, 0, 1'b0); settle();
        expect_words(1, 32'hFEDC_BA98, "R3 spacing 12");
        send_word(32'h0F0F_0F0F, 32, 3, 4, -1, 0, 0, 1'b0); settle();
        expect_words(0, 32'h0, "R3 spacing 7 rejected");
        send_word(32'h3C3C_3C3C, 32, 5, 5, 9, 5, 8, 1'b0); settle();
        expect_words(0, 32'h0, "R3 spacing 13 rejected");

        // R7: recovery after a discard
        send_word(32'h2468_ACE0, 32, 5, 5, -1, 0, 0, 1'b0); settle();
        expect_words(1, 32'h2468_ACE0, "R7 recovery");

        // R2: short pulse
        send_word(32'h5555_AAAA, 32, 5, 5, 15, 2, 5, 1'b0); settle();
        expect_words(0, 32'h0, "R2 short pulse rejected");

        // R4: stalled word
        send_word(32'h7777_7777, 20, 5, 5, -1, 0, 0, 1'b0); settle();
        expect_words(0, 32'h0, "R4 stalled word");

        // R7: too short a gap between words
        send_word(32'hCAFE_0001, 32, 5, 5, -1, 0, 0, 1'b0);
        drive(1'b0, 1'b0, 12);
        send_word(32'hBEEF_0002, 32, 5, 5, -1, 0, 0, 1'b0); settle();
        expect_words(1, 32'hCAFE_0001, "R7 short gap");

        // R9: low speed
        speed_low = 1'b1;
        div = 8;
        drive(1'b0, 1'b0, 40);
        for (int k = 0; k < 2; k++) begin
            logic [31:0] d = $urandom;
            send_word_rand(d);
            settle();
            expect_words(1, d, "R9 low-speed word");
        end
        send_word(32'h6B6B_6B6B, 32, 5, 5, 20, 5, 8, 1'b0); settle();
        expect_words(0, 32'h0, "R9 low-speed spacing 13");
        send_word(32'h0BAD_F00D, 32, 6, 6, -1, 0, 0, 1'b0); settle();
        expect_words(1, 32'h0BAD_F00D, "R9 low-speed spacing 12");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks += 1;
            n_fail   += 1;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule